// File: doc/BRIEF.md
# Receive ATM Cell Packer

This block sits behind the receive side of a byte-wide cell port. It takes one octet per cycle when the valid input is high, together with a start-of-cell marker and a per-octet error flag. It follows the position of each octet inside a fixed-length ATM cell of 4 header octets, one header-check octet and a payload. It drops the check octet and packs everything else into 32-bit words for a downstream cell FIFO.

The FIFO sees three things. A word strobe carries the data. A commit strobe marks the last word of an intact cell. An abort strobe tells the FIFO to rewind its write pointer to the start of the cell. As a result, only whole cells ever become visible downstream. Framing loss and FIFO overflow each raise their own sticky flag, and each flag has its own clear input. After any dropped cell the block hunts for the next start-of-cell.

Top module: `rx_cell_packer`

## Requirements
- R1: With the default payload of 48 octets, a cell is 53 octets long and yields 13 words, so (4+PAY_BYTES)/4 words in general. The octet carrying start-of-cell is position 0. Positions 0 to 3 are the header and become word 0. Position 4 is the check octet and is never written. Positions 5 onward are payload and fill words 1 onward in arrival order.
- R2: Each word is big-endian. The earliest of its four octets sits in bits 31:24 and the latest in bits 7:0.
- R3: `cell_commit` pulses in the same cycle as the write of the last word of a cell. Exactly (4+PAY_BYTES)/4 word writes belong to every committed cell.
- R4: A cycle with `in_valid` low consumes no octet. The position is held and the packing resumes unchanged.
- R5: After reset, and after any dropped cell, the block is hunting. In this state it ignores every octet until one arrives with `in_soc` high and `in_err` low. That octet becomes position 0.
- R6: While locked, a framing error drops the cell, sets `sync_err`, discards the octet and returns the block to hunting. A framing error is either a start-of-cell marker at a position other than 0, or a missing marker at position 0. `cell_abort` pulses only if the dropped cell was past position 0.
- R7: While locked, an octet with `in_err` high drops the cell and returns the block to hunting. `cell_abort` pulses if the position was not 0. No flag is set.
- R8: When a word completes while `fifo_full` is high, that word is not written. `ovfl_err` is set, `cell_abort` pulses and the block returns to hunting.
- R9: `sync_err` and `ovfl_err` stay set until a one-cycle pulse on their own clear input (`clr_sync`, `clr_ovfl`). A set event in the same cycle as a clear leaves the flag set. A clear affects only its own flag.
- R10: All outputs are registered. The effect of an octet appears in the cycle after the clock edge that samples it. Reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An octet is present this cycle |
| in_data | input | 8 | Received octet |
| in_soc | input | 1 | Octet is the first of a cell |
| in_err | input | 1 | Octet was received with an error |
| fifo_full | input | 1 | FIFO cannot accept a word this cycle |
| clr_sync | input | 1 | Clear pulse for `sync_err` |
| clr_ovfl | input | 1 | Clear pulse for `ovfl_err` |
| wr_valid | output | 1 | Word write strobe |
| wr_data | output | 32 | Packed word |
| cell_commit | output | 1 | Last word of an intact cell |
| cell_abort | output | 1 | Rewind FIFO to start of current cell |
| sync_err | output | 1 | Sticky framing-loss flag |
| ovfl_err | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with PAY_BYTES = 8, which gives a 13-octet cell and 3 words. With a cell that short, the bench can sweep a framing error, an errored octet and the onset of FIFO full across every position of the cell. Each position's expected count of surviving writes is computed arithmetically. Gaps in the valid input are inserted at every period from one to three octets, and set-versus-clear collisions on both flags are driven directly.

// File: rtl/rx_cell_pkg.sv
package rx_cell_pkg;

    localparam int HDR_BYTES = 4;
    localparam int CHK_POS   = HDR_BYTES;

    typedef enum logic [1:0] {
        RGN_HDR,
        RGN_CHK,
        RGN_PAY
    } region_e;

    typedef enum logic {
        ST_HUNT,
        ST_LOCK
    } sync_state_e;

    // Per-octet decision handed from the tracker to the datapath
    typedef struct packed {
        logic take;      // octet goes into the packer
        logic lane_end;  // octet closes a word
        logic write;     // closed word is written
        logic commit;    // closed word ends the cell
        logic abort;     // started cell is dropped
        logic sync_evt;  // framing error seen
        logic ovfl_evt;  // word lost to a full FIFO
    } step_s;

    function automatic region_e region_of(int unsigned pos);
        if (pos < HDR_BYTES)
            return RGN_HDR;
        else if (pos == CHK_POS)
            return RGN_CHK;
        else
            return RGN_PAY;
    endfunction

    function automatic logic lane_end(int unsigned pos);
        if (pos < HDR_BYTES)
            return pos == HDR_BYTES - 1;
        else if (pos == CHK_POS)
            return 1'b0;
        else
            return ((pos - CHK_POS - 1) % 4) == 3;
    endfunction

endpackage

// File: rtl/rx_cell_tracker.sv
module rx_cell_tracker
    import rx_cell_pkg::*;
#(
    parameter int PAY_BYTES = 48
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_soc,
    input  logic  in_err,
    input  logic  fifo_full,
    output step_s step
);
    localparam int CELL_BYTES = HDR_BYTES + 1 + PAY_BYTES;
    localparam int POS_W      = $clog2(CELL_BYTES);
    localparam logic [POS_W-1:0] LAST = POS_W'(CELL_BYTES - 1);

    sync_state_e      st;
    logic [POS_W-1:0] pos;
    logic             v_lock, start, bad_soc, err_drop, drop, wdone;
    region_e          rgn;

    always_comb begin
        v_lock   = (st == ST_LOCK) && in_valid;
        start    = (st == ST_HUNT) && in_valid && in_soc && !in_err;
        bad_soc  = v_lock && ((pos == '0) != in_soc);
        err_drop = v_lock && !bad_soc && in_err;
        rgn      = region_of(int'(pos));

        step           = '0;
        step.lane_end  = lane_end(int'(pos));
        step.take      = ((v_lock && !bad_soc && !in_err) || start) && (rgn != RGN_CHK);
        wdone          = step.take && step.lane_end;
        step.ovfl_evt  = wdone && fifo_full;
        step.write     = wdone && !fifo_full;
        step.commit    = step.write && (pos == LAST);
        step.sync_evt  = bad_soc;
        drop           = bad_soc || err_drop || step.ovfl_evt;
        step.abort     = drop && (pos != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_HUNT;
            pos <= '0;
        end else if (drop) begin
            st  <= ST_HUNT;
            pos <= '0;
        end else if (start) begin
            st  <= ST_LOCK;
            pos <= POS_W'(1);
        end else if (v_lock) begin
            pos <= (pos == LAST) ? '0 : pos + POS_W'(1);
        end
    end

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOCK && !in_valid) |=> $stable(pos));                // R4
    AST_SYNC_HUNT: assert property (@(posedge clk) disable iff (rst)
        step.sync_evt |=> (st == ST_HUNT && pos == '0));              // R6
    AST_HUNT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT) |-> (pos == '0));                             // R5

endmodule

// File: rtl/rx_word_assembler.sv
module rx_word_assembler
    import rx_cell_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  step_s       step,
    input  logic [7:0]  in_data,
    output logic        wr_valid,
    output logic [31:0] wr_data
);
    logic [23:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= step.write;
            if (step.take && !step.lane_end)
                acc <= {acc[15:0], in_data};
            if (step.write)
                wr_data <= {acc, in_data};
        end
    end

endmodule

// File: rtl/rx_sticky_flag.sv
module rx_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= set | (flag & ~clr);
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);                                     // R9
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);                                                // R9

endmodule

// File: rtl/rx_cell_packer.sv
module rx_cell_packer
    import rx_cell_pkg::*;
#(
    parameter int PAY_BYTES = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_soc,
    input  logic        in_err,
    input  logic        fifo_full,
    input  logic        clr_sync,
    input  logic        clr_ovfl,
    output logic        wr_valid,
    output logic [31:0] wr_data,
    output logic        cell_commit,
    output logic        cell_abort,
    output logic        sync_err,
    output logic        ovfl_err
);
    localparam int WORDS = (HDR_BYTES + PAY_BYTES) / 4;
    localparam int CNT_W = $clog2(WORDS + 1);

    step_s step;

    rx_cell_tracker #(.PAY_BYTES(PAY_BYTES)) i_tracker (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_soc    (in_soc),
        .in_err    (in_err),
        .fifo_full (fifo_full),
        .step      (step)
    );

    rx_word_assembler i_assembler (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .in_data  (in_data),
        .wr_valid (wr_valid),
        .wr_data  (wr_data)
    );

    rx_sticky_flag i_sync_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (step.sync_evt),
        .clr  (clr_sync),
        .flag (sync_err)
    );

    rx_sticky_flag i_ovfl_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (step.ovfl_evt),
        .clr  (clr_ovfl),
        .flag (ovfl_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_commit <= 1'b0;
            cell_abort  <= 1'b0;
        end else begin
            cell_commit <= step.commit;
            cell_abort  <= step.abort;
        end
    end

    // Checker state: words written so far in the current cell
    logic [CNT_W-1:0] cell_words;
    always_ff @(posedge clk) begin
        if (rst || cell_commit || cell_abort)
            cell_words <= '0;
        else if (wr_valid)
            cell_words <= cell_words + CNT_W'(1);
    end

    AST_COMMIT_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        cell_commit |-> wr_valid);                                    // R3
    AST_CELL_WORDS: assert property (@(posedge clk) disable iff (rst)
        cell_commit |-> (cell_words == CNT_W'(WORDS - 1)));           // R3
    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        fifo_full |=> !wr_valid);                                     // R8
    AST_COMMIT_ABORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cell_commit && cell_abort));                                // R6
    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cell_abort |-> !wr_valid);                                    // R7

endmodule

// File: tb/test_rx_cell_packer.sv
module test_rx_cell_packer;

    localparam int PAY   = 8;
    localparam int CELL  = 5 + PAY;
    localparam int WORDS = (4 + PAY) / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_soc = 1'b0, in_err = 1'b0, fifo_full = 1'b0;
    logic        clr_sync = 1'b0, clr_ovfl = 1'b0;
    logic [7:0]  in_data = '0;
    logic        wr_valid, cell_commit, cell_abort, sync_err, ovfl_err;
    logic [31:0] wr_data;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_commit = 0, n_abort = 0;
    logic [31:0] wbuf [0:63];

    always #5 clk = ~clk;

    rx_cell_packer #(.PAY_BYTES(PAY)) i_rx_cell_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_soc(in_soc), .in_err(in_err), .fifo_full(fifo_full),
        .clr_sync(clr_sync), .clr_ovfl(clr_ovfl), .wr_valid(wr_valid),
        .wr_data(wr_data), .cell_commit(cell_commit), .cell_abort(cell_abort),
        .sync_err(sync_err), .ovfl_err(ovfl_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                wbuf[n_wr % 64] = wr_data;
                n_wr++;
            end
            if (cell_commit) n_commit++;
            if (cell_abort)  n_abort++;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gb(int seed, int i);
        return 8'(seed * 29 + i * 11 + 3);
    endfunction

    function automatic logic [31:0] exp_word(int seed, int k);
        int b = (k == 0) ? 0 : 5 + 4 * (k - 1);
        return {gb(seed, b), gb(seed, b + 1), gb(seed, b + 2), gb(seed, b + 3)};
    endfunction

    // words closed at positions strictly below p
    function automatic int words_before(int p);
        return ((p >= 4) ? 1 : 0) + ((p > 5) ? (p - 5) / 4 : 0);
    endfunction

    task automatic drive(input logic [7:0] d, input logic s, input logic e, input logic f);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_soc = s; in_err = e; fifo_full = f;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_soc = 1'b0; in_err = 1'b0; fifo_full = 1'b0;
            clr_sync = 1'b0; clr_ovfl = 1'b0;
        end
    endtask

    // kind: 0 clean, 1 stray marker at cut, 2 errored octet at cut, 3 missing marker
    task automatic send_cell(input int seed, input int gap, input int cut, input int kind, input int full_from);
        for (int i = 0; i < CELL; i++) begin
            drive(gb(seed, i),
                  (i == 0 && kind != 3) || (i == cut && kind == 1),
                  (i == cut && kind == 2),
                  i >= full_from);
            if (gap > 0 && (i % gap) == gap - 1) idle(1);
        end
        idle(3);
    endtask

    task automatic check_good(input int seed, input int gap, input string req);
        int w0 = n_wr, c0 = n_commit;
        send_cell(seed, gap, -1, 0, CELL);
        chk(n_wr - w0 == WORDS, req, n_wr - w0, WORDS);
        chk(n_commit - c0 == 1, "R3", n_commit - c0, 1);
        for (int k = 0; k < WORDS; k++)
            chk(wbuf[(w0 + k) % 64] == exp_word(seed, k), req,
                wbuf[(w0 + k) % 64], exp_word(seed, k));
    endtask

    task automatic pulse_clears();
        @(negedge clk); clr_sync = 1'b1; clr_ovfl = 1'b1;
        idle(1);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        int w0, c0, a0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({wr_valid, cell_commit, cell_abort, sync_err, ovfl_err} == 5'b0, "R10",
            {wr_valid, cell_commit, cell_abort, sync_err, ovfl_err}, 0);

        // R5: hunting ignores octets without a clean marker
        w0 = n_wr;
        for (int i = 0; i < 20; i++) drive(gb(9, i), 1'b0, 1'b0, 1'b0);
        drive(8'hAA, 1'b1, 1'b1, 1'b0);
        for (int i = 1; i < CELL; i++) drive(gb(9, i), 1'b0, 1'b0, 1'b0);
        idle(3);
        chk(n_wr == w0 && !sync_err && n_abort == 0, "R5", n_wr - w0, 0);

        // R1 R2 R4: clean cells with gap patterns
        for (int g = 0; g <= 3; g++) check_good(g + 1, g, (g == 0) ? "R1" : "R4");
        check_good(40, 0, "R2");

        // R10: first word appears one cycle after its closing octet
        for (int i = 0; i < 4; i++) drive(gb(50, i), i == 0, 1'b0, 1'b0);
        @(negedge clk); in_valid = 1'b0;
        chk(wr_valid && wr_data == exp_word(50, 0), "R10", wr_data, exp_word(50, 0));
        @(negedge clk);
        chk(!wr_valid, "R4", wr_valid, 0);
        w0 = n_wr; c0 = n_commit;
        for (int i = 4; i < CELL; i++) drive(gb(50, i), 1'b0, 1'b0, 1'b0);
        idle(3);
        chk(n_wr - w0 == WORDS - 1 && n_commit - c0 == 1, "R4", n_wr - w0, WORDS - 1);
        chk(wbuf[(n_wr - 1) % 64] == exp_word(50, WORDS - 1), "R1",
            wbuf[(n_wr - 1) % 64], exp_word(50, WORDS - 1));

        // R6: stray marker swept over every nonzero position
        for (int p = 1; p < CELL; p++) begin
            w0 = n_wr; c0 = n_commit; a0 = n_abort;
            send_cell(60 + p, 0, p, 1, CELL);
            chk(n_wr - w0 == words_before(p), "R6", n_wr - w0, words_before(p));
            chk(n_abort - a0 == 1 && n_commit == c0, "R6", n_abort - a0, 1);
            chk(sync_err && !ovfl_err, "R6", sync_err, 1);
            pulse_clears();
            chk(!sync_err, "R9", sync_err, 0);
            check_good(p, 0, "R5");
        end

        // R6: missing marker at position 0 (block locked after a clean cell)
        a0 = n_abort; w0 = n_wr;
        send_cell(77, 0, 0, 3, CELL);
        chk(sync_err && n_abort == a0 && n_wr == w0, "R6", n_abort - a0, 0);

        // R9: set and clear in the same cycle leaves the flag set
        check_good(78, 0, "R9");
        @(negedge clk);
        in_valid = 1'b1; in_soc = 1'b0; in_err = 1'b0; in_data = 8'h11; clr_sync = 1'b1;
        idle(2);
        chk(sync_err, "R9", sync_err, 1);
        pulse_clears();
        chk(!sync_err, "R9", sync_err, 0);

        // R7: errored octet swept over every position
        for (int p = 0; p < CELL; p++) begin
            check_good(90 + p, 0, "R7");
            w0 = n_wr; c0 = n_commit; a0 = n_abort;
            send_cell(100 + p, 0, p, 2, CELL);
            chk(n_wr - w0 == words_before(p), "R7", n_wr - w0, words_before(p));
            chk(n_abort - a0 == ((p > 0) ? 1 : 0) && n_commit == c0, "R7",
                n_abort - a0, (p > 0) ? 1 : 0);
            chk(!sync_err && !ovfl_err, "R7", {sync_err, ovfl_err}, 0);
        end

        // R8: FIFO full from every position onward
        for (int p = 0; p < CELL; p++) begin
            w0 = n_wr; c0 = n_commit; a0 = n_abort;
            send_cell(120 + p, 0, -1, 0, p);
            chk(n_wr - w0 == words_before(p), "R8", n_wr - w0, words_before(p));
            chk(n_abort - a0 == 1 && n_commit == c0, "R8", n_abort - a0, 1);
            chk(ovfl_err && !sync_err, "R8", ovfl_err, 1);
            // R9: clearing the sync flag leaves overflow set
            @(negedge clk); clr_sync = 1'b1;
            idle(1);
            chk(ovfl_err, "R9", ovfl_err, 1);
            @(negedge clk); clr_ovfl = 1'b1;
            idle(1);
            chk(!ovfl_err, "R9", ovfl_err, 0);
            check_good(130 + p, 1, "R8");
        end

        report();
    end

endmodule